// File: doc/BRIEF.md
# Multiprocessor-Aware Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters for a host. An external prescaler supplies a one-cycle oversampling tick. The receiver counts either 16 or 8 ticks per bit. A double-speed control selects the shorter count, which doubles the bit rate for the same tick rate. The receiver finds a falling edge on the idle-high line and confirms the start bit by voting. It then decides each following bit by a 2-of-3 vote of the samples at the bit centre. The result goes into a one-deep receive buffer, with the ninth data bit kept in its own output. The host sees a receive-complete flag and status flags for frame error, overrun and parity error, along with an interrupt request that is gated by enables.

In multiprocessor mode, each frame carries an address marker. In 9-bit characters the marker is the ninth data bit. In shorter characters it is one extra bit placed right after the last data bit. Frames whose marker is low are discarded without any trace at the host side. Clearing the enable stops reception at once, empties the buffer, clears every status flag, and hands the line back to the general-purpose port function.

Top module: `mp_usart_rx`

## Requirements
- R1: After reset `rx_lo`, `rx_b8`, `rxc`, `fe`, `dor`, `pe` and `irq` are all 0.
- R2: A frame is a low start bit, then N data bits sent LSB first, then the optional marker bit, then the optional parity bit, then a stop bit. `size_code` selects N: 000→5, 001→6, 010→7, 011→8, 111→9, and any other code→8. Data bits above N read as 0. A completed frame appears on `rx_lo`/`rx_b8` with `rxc` set to 1.
- R3: With `dbl_speed`=0 a bit lasts 16 ticks. With `dbl_speed`=1 it lasts 8 ticks.
- R4: A start is accepted only if at least 2 of the 3 centre samples of the start bit are low. A shorter low pulse is ignored. A single wrong centre sample inside a data bit does not change that bit.
- R5: If the stop bit is sampled low, `fe` is set together with `rxc` for that character.
- R6: `par_mode` selects the parity check: 0x means none, 10 means even, 11 means odd. The parity bit covers the N data bits only. On a mismatch, `pe` is set together with `rxc`.
- R7: If a frame completes while `rxc` is still 1 and no read is made in that cycle, `dor` goes to 1 and the buffered character is kept unchanged.
- R8: A one-cycle `rd_lo` pulse marks the buffer as read and clears `rxc`, `fe`, `pe` and `dor`. `rx_b8` holds data bit 8, which is 0 for sizes below 9.
- R9: With `mp_mode`=1, a frame whose marker is 0 leaves every output unchanged. A frame whose marker is 1 is received normally.
- R10: `irq` is 1 only while `rxc_ie`, `glob_ie` and `rxc` are all 1.
- R11: While `rx_en`=0, `rxc`, `fe`, `dor` and `pe` are held at 0, no frame is received, and `rxd_own` is 0. With `rx_en`=1, `rxd_own` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle oversampling tick from the prescaler |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| mp_mode | input | 1 | Multiprocessor address filtering |
| size_code | input | 3 | Character size code |
| par_mode | input | 2 | Parity check selection |
| rxc_ie | input | 1 | Receive interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| rd_lo | input | 1 | Read strobe for the low data byte |
| rx_lo | output | 8 | Received data bits 7..0 |
| rx_b8 | output | 1 | Received data bit 8 |
| rxc | output | 1 | Receive complete |
| fe | output | 1 | Frame error |
| dor | output | 1 | Data overrun |
| pe | output | 1 | Parity error |
| irq | output | 1 | Receive interrupt request |
| rxd_own | output | 1 | Receiver owns the serial pin |

## Verification
A bit counter or oversample counter that drifts shows up within one character as wrong data or a false `fe`. The `rxc` flag still rises, so the data value has to be compared, not only the flag. A voting fault that is triggered by one short glitch shows up on the very next frame as a flipped data bit or a phantom character. State left over after a discard or a flush only appears on the following frame, or as `rxc`/`dor` staying set. For that reason each scenario sends a second frame, or reads the flags again after the event.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_MARK, ST_PAR, ST_STOP
  } urx_state_e;

  // Character size decode: codes 0..3 give 5..8 bits, 7 gives 9, the rest fall back to 8
  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // XOR of the lowest n bits of d
  function automatic logic low_xor(input logic [8:0] d, input logic [3:0] n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (4'(i) < n) r = r ^ d[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              dbl,
  input  logic [3:0]        nbits,
  input  logic              mpm,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              frame_done,
  output logic              start_rej,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_mark,
  output logic              fr_stop_bad,
  output logic              fr_par_bad
);
  localparam int CNT_W = $clog2(OS_NORM);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OS_NORM - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OS_FAST - 1);
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OS_NORM / 2 - 1);
  localparam logic [CNT_W-1:0] MID_F  = CNT_W'(OS_FAST / 2 - 1);

  urx_state_e        state;
  logic [CNT_W-1:0]  os_cnt;
  logic [3:0]        bit_idx;
  logic              samp_a, samp_b, bit_now, mark_q, par_q;
  logic [DATA_W-1:0] data_q;

  logic [CNT_W-1:0] os_last, c_mid;
  logic at_a, at_b, at_dec, at_end, vote, last_data;

  assign os_last   = dbl ? LAST_F : LAST_N;
  assign c_mid     = dbl ? MID_F : MID_N;
  assign at_a      = (os_cnt == c_mid);
  assign at_b      = (os_cnt == c_mid + 1'b1);
  assign at_dec    = (os_cnt == c_mid + 2'd2);
  assign at_end    = (os_cnt == os_last);
  assign vote      = maj3(samp_a, samp_b, rxd_s);
  assign last_data = (bit_idx == nbits - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      os_cnt      <= '0;
      bit_idx     <= '0;
      samp_a      <= 1'b1;
      samp_b      <= 1'b1;
      bit_now     <= 1'b1;
      mark_q      <= 1'b0;
      par_q       <= 1'b0;
      data_q      <= '0;
      frame_done  <= 1'b0;
      start_rej   <= 1'b0;
      fr_stop_bad <= 1'b0;
      fr_par_bad  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      start_rej  <= 1'b0;
      if (!en) begin
        state  <= ST_IDLE;
        os_cnt <= '0;
      end else if (tick) begin
        if (state == ST_IDLE) begin
          if (!rxd_s) begin
            state   <= ST_START;
            os_cnt  <= CNT_W'(1);
            bit_idx <= '0;
            data_q  <= '0;
            mark_q  <= 1'b0;
          end
        end else begin
          os_cnt <= at_end ? '0 : os_cnt + 1'b1;
          if (at_a) samp_a <= rxd_s;
          if (at_b) samp_b <= rxd_s;
          if (at_dec) begin
            bit_now <= vote;
            if (state == ST_START && vote) begin
              state     <= ST_IDLE;
              start_rej <= 1'b1;
            end
            if (state == ST_STOP) begin
              state       <= ST_IDLE;
              frame_done  <= 1'b1;
              fr_stop_bad <= ~vote;
              fr_par_bad  <= par_en & ((low_xor(data_q, nbits) ^ par_odd) != par_q);
            end
          end
          if (at_end) begin
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                data_q[bit_idx] <= bit_now;
                if (last_data) begin
                  if (mpm && nbits != 4'd9) state <= ST_MARK;
                  else if (par_en)          state <= ST_PAR;
                  else                      state <= ST_STOP;
                end else begin
                  bit_idx <= bit_idx + 4'd1;
                end
              end
              ST_MARK: begin
                mark_q <= bit_now;
                state  <= par_en ? ST_PAR : ST_STOP;
              end
              ST_PAR: begin
                par_q <= bit_now;
                state <= ST_STOP;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign fr_data = data_q;
  assign fr_mark = (nbits == 4'd9) ? data_q[8] : mark_q;

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && start_rej)); // R4
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(tick)); // R3
  AST_REJ_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |-> (state == ST_IDLE)); // R4
endmodule

// File: rtl/urx_buffer.sv
module urx_buffer #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mpm,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_mark,
  input  logic              fr_stop_bad,
  input  logic              fr_par_bad,
  input  logic              rd_lo,
  input  logic              rxc_ie,
  input  logic              glob_ie,
  output logic [7:0]        rx_lo,
  output logic              rx_b8,
  output logic              rxc,
  output logic              fe,
  output logic              dor,
  output logic              pe,
  output logic              irq
);
  logic              accept;
  logic [DATA_W-1:0] buf_q;

  assign accept = frame_done & (~mpm | fr_mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      rxc   <= 1'b0;
      fe    <= 1'b0;
      dor   <= 1'b0;
      pe    <= 1'b0;
    end else if (!en) begin
      buf_q <= '0;
      rxc   <= 1'b0;
      fe    <= 1'b0;
      dor   <= 1'b0;
      pe    <= 1'b0;
    end else if (accept && (!rxc || rd_lo)) begin
      buf_q <= fr_data;
      rxc   <= 1'b1;
      fe    <= fr_stop_bad;
      pe    <= fr_par_bad;
      dor   <= 1'b0;
    end else if (accept) begin
      dor <= 1'b1;
    end else if (rd_lo) begin
      rxc <= 1'b0;
      fe  <= 1'b0;
      pe  <= 1'b0;
      dor <= 1'b0;
    end
  end

  assign rx_lo = buf_q[7:0];
  assign rx_b8 = buf_q[8];
  assign irq   = rxc_ie & glob_ie & rxc;

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rxc && !fe && !dor && !pe)); // R11
  AST_MP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mpm && !fr_mark && !rxc) |=> !rxc); // R9
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && accept && rxc && !rd_lo) |=> (dor && $stable(rx_lo) && $stable(rx_b8))); // R7
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_lo && !frame_done) |=> !irq); // R10
endmodule

// File: rtl/mp_usart_rx.sv
module mp_usart_rx #(
  parameter int OS_NORM     = 16,
  parameter int OS_FAST     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       rx_en,
  input  logic       dbl_speed,
  input  logic       mp_mode,
  input  logic [2:0] size_code,
  input  logic [1:0] par_mode,
  input  logic       rxc_ie,
  input  logic       glob_ie,
  input  logic       rd_lo,
  output logic [7:0] rx_lo,
  output logic       rx_b8,
  output logic       rxc,
  output logic       fe,
  output logic       dor,
  output logic       pe,
  output logic       irq,
  output logic       rxd_own
);
  import urx_pkg::*;
  localparam int DATA_W = 9;

  logic              rxd_s;
  logic              frame_done, start_rej;
  logic [DATA_W-1:0] fr_data;
  logic              fr_mark, fr_stop_bad, fr_par_bad;
  logic [3:0]        nbits;

  assign nbits   = size_bits(size_code);
  assign rxd_own = rx_en;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  urx_frame #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(baud_tick), .rxd_s(rxd_s),
    .dbl(dbl_speed), .nbits(nbits), .mpm(mp_mode),
    .par_en(par_mode[1]), .par_odd(par_mode[0]),
    .frame_done(frame_done), .start_rej(start_rej), .fr_data(fr_data),
    .fr_mark(fr_mark), .fr_stop_bad(fr_stop_bad), .fr_par_bad(fr_par_bad)
  );

  urx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .mpm(mp_mode),
    .frame_done(frame_done), .fr_data(fr_data), .fr_mark(fr_mark),
    .fr_stop_bad(fr_stop_bad), .fr_par_bad(fr_par_bad), .rd_lo(rd_lo),
    .rxc_ie(rxc_ie), .glob_ie(glob_ie), .rx_lo(rx_lo), .rx_b8(rx_b8),
    .rxc(rxc), .fe(fe), .dor(dor), .pe(pe), .irq(irq)
  );

  AST_REJ_NO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rej && !rxc) |=> !rxc); // R4
endmodule

// File: tb/tb_mp_usart_rx.sv
module tb_mp_usart_rx;
  localparam int T  = 4;      // clocks per oversampling tick
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, baud_tick = 1'b0, rx_en = 1'b0, dbl_speed = 1'b0, mp_mode = 1'b0;
  logic [2:0] size_code = 3'b011;
  logic [1:0] par_mode = 2'b00;
  logic rxc_ie = 1'b0, glob_ie = 1'b0, rd_lo = 1'b0;
  logic [7:0] rx_lo;
  logic rx_b8, rxc, fe, dor, pe, irq, rxd_own;

  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == T - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == T - 1);
  end

  mp_usart_rx dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick), .rx_en(rx_en),
    .dbl_speed(dbl_speed), .mp_mode(mp_mode), .size_code(size_code),
    .par_mode(par_mode), .rxc_ie(rxc_ie), .glob_ie(glob_ie), .rd_lo(rd_lo),
    .rx_lo(rx_lo), .rx_b8(rx_b8), .rxc(rxc), .fe(fe), .dor(dor), .pe(pe),
    .irq(irq), .rxd_own(rxd_own)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic ref_xor(input logic [8:0] d, input int n);
    logic r = 1'b0;
    for (int i = 0; i < n; i++) r = r ^ d[i];
    return r;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int os, input bit glitch);
    rxd = v;
    if (glitch) begin
      wait_clk((os / 2 - 1) * T);
      rxd = ~v;
      wait_clk(T);
      rxd = v;
      wait_clk((os / 2) * T);
    end else begin
      wait_clk(os * T);
    end
  endtask

  // pm: 0 none, 2 even, 3 odd ; glitch_bit < 0 means no glitch
  task automatic send_frame(input logic [8:0] d, input int nb, input int os,
                            input bit has_mark, input logic mark, input int pm,
                            input bit bad_par, input logic stop_v, input int glitch_bit);
    logic p;
    send_bit(1'b0, os, 1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i], os, i == glitch_bit);
    if (has_mark) send_bit(mark, os, 1'b0);
    if (pm >= 2) begin
      p = ref_xor(d, nb) ^ pm[0] ^ bad_par;
      send_bit(p, os, 1'b0);
    end
    send_bit(stop_v, os, 1'b0);
    rxd = 1'b1;
    wait_clk(3 * os * T);
  endtask

  task automatic read_lo();
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    chk("R1 rxc", rxc, 0);   chk("R1 fe", fe, 0);   chk("R1 dor", dor, 0);
    chk("R1 pe", pe, 0);     chk("R1 irq", irq, 0); chk("R1 data", {rx_b8, rx_lo}, 0);
    chk("R11 own off", rxd_own, 0);
  endtask

  task automatic t_basic();
    rx_en = 1'b1; size_code = 3'b011; wait_clk(4);
    chk("R11 own on", rxd_own, 1);
    send_frame(9'h0A5, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R2 rxc 8b", rxc, 1); chk("R2 data 8b", rx_lo, 'hA5);
    chk("R5 fe clean", fe, 0); chk("R8 b8 zero", rx_b8, 0);
    read_lo();
    chk("R8 rxc cleared", rxc, 0);
  endtask

  task automatic t_sizes();
    size_code = 3'b000;
    send_frame(9'h1F5, 5, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R2 data 5b", rx_lo, 'h15);
    read_lo();
    size_code = 3'b010;
    send_frame(9'h0D3, 7, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R2 data 7b", rx_lo, 'h53);
    read_lo();
    size_code = 3'b111;
    send_frame(9'h1A3, 9, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R8 b8 one", rx_b8, 1); chk("R2 data 9b", rx_lo, 'hA3);
    read_lo();
    size_code = 3'b011;
  endtask

  task automatic t_double();
    dbl_speed = 1'b1;
    send_frame(9'h03C, 8, 8, 0, 0, 0, 0, 1'b1, -1);
    chk("R3 double rxc", rxc, 1); chk("R3 double data", rx_lo, 'h3C);
    read_lo();
    dbl_speed = 1'b0;
    send_frame(9'h0C3, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R3 normal data", rx_lo, 'hC3);
    read_lo();
  endtask

  task automatic t_vote();
    rxd = 1'b0; wait_clk(T); rxd = 1'b1;
    wait_clk(40 * T);
    chk("R4 short start ignored", rxc, 0);
    send_frame(9'h0FF, 8, 16, 0, 0, 0, 0, 1'b1, 3);
    chk("R4 glitch rxc", rxc, 1); chk("R4 glitch data", rx_lo, 'hFF);
    read_lo();
  endtask

  task automatic t_frame_err();
    send_frame(9'h055, 8, 16, 0, 0, 0, 0, 1'b0, -1);
    chk("R5 fe set", fe, 1); chk("R5 rxc with fe", rxc, 1);
    read_lo();
    chk("R8 fe cleared", fe, 0);
  endtask

  task automatic t_parity();
    par_mode = 2'b10;
    send_frame(9'h007, 8, 16, 0, 0, 2, 0, 1'b1, -1);
    chk("R6 even ok", pe, 0); chk("R6 even data", rx_lo, 'h07);
    read_lo();
    send_frame(9'h007, 8, 16, 0, 0, 2, 1, 1'b1, -1);
    chk("R6 even bad", pe, 1);
    read_lo();
    chk("R8 pe cleared", pe, 0);
    par_mode = 2'b11;
    send_frame(9'h081, 8, 16, 0, 0, 3, 0, 1'b1, -1);
    chk("R6 odd ok", pe, 0);
    read_lo();
    send_frame(9'h081, 8, 16, 0, 0, 3, 1, 1'b1, -1);
    chk("R6 odd bad", pe, 1);
    read_lo();
    par_mode = 2'b00;
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    send_frame(9'h022, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R7 dor set", dor, 1); chk("R7 old kept", rx_lo, 'h11);
    read_lo();
    chk("R8 dor cleared", dor, 0);
  endtask

  task automatic t_mp();
    mp_mode = 1'b1;
    send_frame(9'h0AA, 8, 16, 1, 1'b0, 0, 0, 1'b1, -1);
    chk("R9 8b no-marker dropped", rxc, 0);
    send_frame(9'h05B, 8, 16, 1, 1'b1, 0, 0, 1'b1, -1);
    chk("R9 8b marker rxc", rxc, 1); chk("R9 8b marker data", rx_lo, 'h5B);
    read_lo();
    send_frame(9'h0C4, 8, 16, 1, 1'b0, 0, 0, 1'b1, -1);
    chk("R9 data kept after drop", rx_lo, 'h5B);
    size_code = 3'b111;
    send_frame(9'h077, 9, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R9 9b no-marker dropped", rxc, 0);
    send_frame(9'h177, 9, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R9 9b marker rxc", rxc, 1); chk("R9 9b b8", rx_b8, 1);
    read_lo();
    size_code = 3'b011; mp_mode = 1'b0;
  endtask

  task automatic t_irq();
    send_frame(9'h099, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    rxc_ie = 1'b1; glob_ie = 1'b0; wait_clk(2);
    chk("R10 no global", irq, 0);
    glob_ie = 1'b1; wait_clk(2);
    chk("R10 all set", irq, 1);
    rxc_ie = 1'b0; wait_clk(2);
    chk("R10 no local", irq, 0);
    rxc_ie = 1'b1;
    read_lo();
    chk("R10 after read", irq, 0);
    rxc_ie = 1'b0; glob_ie = 1'b0;
  endtask

  task automatic t_flush();
    send_frame(9'h066, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    send_frame(9'h067, 8, 16, 0, 0, 0, 0, 1'b0, -1);
    chk("R11 pre rxc", rxc, 1); chk("R11 pre dor", dor, 1);
    rx_en = 1'b0; wait_clk(2);
    chk("R11 flush rxc", rxc, 0); chk("R11 flush dor", dor, 0);
    chk("R11 flush fe", fe, 0); chk("R11 own released", rxd_own, 0);
    send_frame(9'h033, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R11 disabled ignores", rxc, 0);
    rx_en = 1'b1; wait_clk(4);
    send_frame(9'h034, 8, 16, 0, 0, 0, 0, 1'b1, -1);
    chk("R11 re-enabled data", rx_lo, 'h34);
    read_lo();
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_basic();
    t_sizes();
    t_double();
    t_vote();
    t_frame_err();
    t_parity();
    t_overrun();
    t_mp();
    t_irq();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule